// File: doc/BRIEF.md
# Ready/Busy and Interrupt Pin Controller

This block drives one shared card output pin whose meaning and polarity follow the card's operating mode. In memory mode the pin reports readiness: high when the card can take a new transfer, low while it is busy or still initialising after reset. In I/O mode the same pin is an active-low interrupt request. It is either a fixed-length low strobe (pulse style) or a low level held until the host acknowledges it (level style). In the disk-emulation mode the pin is an active-high interrupt request that a device-control mask bit can suppress.

The controller takes the mode code, the core's busy flag, its initialisation-done flag, an interrupt event from the command engine, an interrupt-clear event (for example a status read), the pulse/level select and the mask bit. It produces the pin level and an output enable. A mode change is registered on the next clock edge and discards any interrupt that was pending.

Top module: `rbi_pin_ctrl`

## Requirements
- R1: With mode code 0 (memory) and initialisation complete, `pin_out` is 1 while `core_busy` is 0 and 0 while `core_busy` is 1, in the same cycle.
- R2: From reset, the registered mode is 0 and `pin_out` stays 0. It stays 0 after reset is released until `init_done` has been seen high. That flag is sticky until the next reset, so dropping `init_done` later has no effect.
- R3: With mode code 1 (I/O), `pin_out` is 1 when idle and goes low on an interrupt. `pulse_sel`=1 selects pulse style and `pulse_sel`=0 selects level style.
- R4: In level style, an `irq_event` sampled on a clock edge drives `pin_out` low after that edge. The pin stays low until an edge that samples `irq_clear`=1 with `irq_event`=0. An event and a clear in the same cycle leave the pin low.
- R5: In pulse style, an `irq_event` drives `pin_out` low for exactly PULSE_LEN (default 8) cycles, starting after the sampling edge. An event that arrives during a strobe neither restarts nor extends it.
- R6: With mode code 2 (disk emulation), `pin_out` is active high. An `irq_event` sets it after the edge, and an `irq_clear` without an event resets it.
- R7: In mode 2, `irq_mask`=1 forces `pin_out` to 0 in the same cycle. The pending interrupt is kept and shows again once the mask drops.
- R8: A change of `mode_sel` takes effect at the next clock edge. That edge discards all pending or strobing interrupt state, so the new mode starts idle.
- R9: Mode code 3 is reserved: `pin_oe` is 0 and `pin_out` is 0. In codes 0 to 2, `pin_oe` is 1.
- R10: `irq_event` has no effect on `pin_out` in mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | Mode code: 0 memory, 1 I/O, 2 disk emulation, 3 reserved |
| core_busy | input | 1 | Core is busy with a transfer |
| init_done | input | 1 | Core initialisation has completed |
| irq_event | input | 1 | Interrupt request from the command engine |
| irq_clear | input | 1 | Interrupt acknowledge (e.g. status read) |
| pulse_sel | input | 1 | I/O mode style: 1 pulse, 0 level |
| irq_mask | input | 1 | Interrupt mask for disk-emulation mode |
| pin_out | output | 1 | Pin level |
| pin_oe | output | 1 | Pin output enable |

## Verification
The busy flag is toggled in memory mode both before and after initialisation. This separates the reset hold from plain busy tracking. In I/O pulse style a second event is injected mid-strobe and the low cycles are counted, which shows whether a strobe is of fixed length or retriggerable. Level style is driven with a lone event, with an event coinciding with a clear, and with a lone clear, to expose the set-over-clear priority. Mode switches with an interrupt outstanding, and masking and unmasking in disk-emulation mode, show whether state is flushed on a mode change but kept across a mask.

// File: rtl/rbi_pkg.sv
// Package: shared mode encoding for the ready/busy/interrupt pin controller.
// Assumes the mode code is supplied by configuration logic outside this block.
package rbi_pkg;
    typedef enum logic [1:0] {
        RBI_MEM = 2'd0,
        RBI_IO  = 2'd1,
        RBI_IDE = 2'd2,
        RBI_OFF = 2'd3
    } rbi_mode_e;
endpackage

// File: rtl/rbi_mode_track.sv
// Registers the requested mode and flags the cycle in which it changes.
// Assumes mode_sel is synchronous to clk; flush is combinational and valid
// only in the cycle before the new mode becomes visible.
module rbi_mode_track
    import rbi_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic [1:0] mode_sel,
    output rbi_mode_e mode_q,
    output logic      flush
);
    // Mode register: takes the new code on every edge, memory after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= RBI_MEM;
        else        mode_q <= rbi_mode_e'(mode_sel);
    end

    // Change detect: request differs from the mode now in force.
    always_comb flush = (mode_sel != mode_q);
endmodule

// File: rtl/rbi_ready_track.sv
// Remembers that core initialisation has completed since the last reset.
// Assumes init_done may fall again later; readiness must not drop with it.
module rbi_ready_track (
    input  logic clk,
    input  logic rst_n,
    input  logic init_done,
    output logic init_seen
);
    // Sticky flag: set by init_done, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)         init_seen <= 1'b0;
        else if (init_done) init_seen <= 1'b1;
    end

    assert_init_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        init_seen |=> init_seen);
endmodule

// File: rtl/rbi_io_irq.sv
// I/O mode interrupt engine: a fixed-length strobe (pulse style) or a held
// request (level style). Output io_active is high while the pin must be low.
// Assumes enable is high only while the I/O mode is in force.
module rbi_io_irq #(
    parameter int PULSE_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic flush,
    input  logic pulse_sel,
    input  logic irq_event,
    input  logic irq_clear,
    output logic io_active
);
    localparam int CW = (PULSE_LEN < 2) ? 1 : $clog2(PULSE_LEN + 1);
    localparam logic [CW-1:0] LOAD = CW'(PULSE_LEN);

    logic [CW-1:0] cnt_q;
    logic          lvl_q;

    // Strobe counter: loads on an event when idle, counts down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)                          cnt_q <= '0;
        else if (cnt_q != '0)                         cnt_q <= cnt_q - 1'b1;
        else if (enable && pulse_sel && irq_event)    cnt_q <= LOAD;
    end

    // Level request: set by an event, dropped by a clear without an event.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)                          lvl_q <= 1'b0;
        else if (enable && !pulse_sel && irq_event)   lvl_q <= 1'b1;
        else if (enable && irq_clear)                 lvl_q <= 1'b0;
    end

    // Request output: either engine active pulls the pin low.
    always_comb io_active = (cnt_q != '0) || lvl_q;

    assert_pulse_no_extend_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0 && !flush) |=> (cnt_q == $past(cnt_q) - 1'b1));
    assert_level_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_q && !irq_clear && !flush) |=> lvl_q);
endmodule

// File: rtl/rbi_ide_irq.sv
// Disk-emulation interrupt latch: set by an event, cleared by an acknowledge.
// Assumes enable is high only while the disk-emulation mode is in force.
module rbi_ide_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic flush,
    input  logic irq_event,
    input  logic irq_clear,
    output logic ide_pend
);
    // Pending latch: event wins over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)            ide_pend <= 1'b0;
        else if (enable && irq_event)   ide_pend <= 1'b1;
        else if (enable && irq_clear)   ide_pend <= 1'b0;
    end

    assert_ide_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && irq_event && !flush) |=> ide_pend);
endmodule

// File: rtl/rbi_pin_ctrl.sv
// Top: drives the shared ready/busy/interrupt pin according to the mode.
// Memory: ready high / busy low. I/O: active-low interrupt. Disk emulation:
// active-high interrupt with mask. Reserved code: pin released.
// Assumes all inputs are synchronous to clk; reset is synchronous active-low.
module rbi_pin_ctrl
    import rbi_pkg::*;
#(
    parameter int PULSE_LEN = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_sel,
    input  logic       core_busy,
    input  logic       init_done,
    input  logic       irq_event,
    input  logic       irq_clear,
    input  logic       pulse_sel,
    input  logic       irq_mask,
    output logic       pin_out,
    output logic       pin_oe
);
    rbi_mode_e mode_q;
    logic      flush;
    logic      init_seen;
    logic      io_active;
    logic      ide_pend;

    rbi_mode_track u_mode (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .mode_q(mode_q), .flush(flush)
    );

    rbi_ready_track u_ready (
        .clk(clk), .rst_n(rst_n), .init_done(init_done), .init_seen(init_seen)
    );

    rbi_io_irq #(.PULSE_LEN(PULSE_LEN)) u_io (
        .clk(clk), .rst_n(rst_n), .enable(mode_q == RBI_IO), .flush(flush),
        .pulse_sel(pulse_sel), .irq_event(irq_event), .irq_clear(irq_clear),
        .io_active(io_active)
    );

    rbi_ide_irq u_ide (
        .clk(clk), .rst_n(rst_n), .enable(mode_q == RBI_IDE), .flush(flush),
        .irq_event(irq_event), .irq_clear(irq_clear), .ide_pend(ide_pend)
    );

    // Pin mux: choose meaning and polarity from the mode in force.
    always_comb begin
        pin_oe  = 1'b1;
        pin_out = 1'b0;
        unique case (mode_q)
            RBI_MEM: pin_out = init_seen && !core_busy;
            RBI_IO:  pin_out = !io_active;
            RBI_IDE: pin_out = ide_pend && !irq_mask;
            RBI_OFF: pin_oe  = 1'b0;
        endcase
    end

    assert_busy_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == RBI_MEM && core_busy) |-> !pin_out);
    assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!io_active && !ide_pend));
    assert_mask_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == RBI_IDE && irq_mask) |-> !pin_out);
    assert_reserved_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == RBI_OFF) |-> (!pin_oe && !pin_out));
endmodule

// File: tb/rbi_pin_ctrl_tb.sv
`timescale 1ns/1ps
module rbi_pin_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] mode_sel;
    logic       core_busy, init_done, irq_event, irq_clear, pulse_sel, irq_mask;
    logic       pin_out, pin_oe;
    int         total = 0;
    int         bad = 0;

    always #2.5 clk = ~clk;

    rbi_pin_ctrl #(.PULSE_LEN(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .core_busy(core_busy),
        .init_done(init_done), .irq_event(irq_event), .irq_clear(irq_clear),
        .pulse_sel(pulse_sel), .irq_mask(irq_mask),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic cyc(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic t_reset_ready();
        rst_n = 0; mode_sel = 0; core_busy = 0; init_done = 0;
        irq_event = 0; irq_clear = 0; pulse_sel = 0; irq_mask = 0;
        cyc(3);
        check("R2 pin in reset", pin_out, 0);
        check("R9 oe in reset", pin_oe, 1);
        rst_n = 1; cyc(2);
        check("R2 busy before init", pin_out, 0);
        init_done = 1; cyc();
        init_done = 0; cyc();
        check("R2 ready after init, sticky", pin_out, 1);
        core_busy = 1; #1;
        check("R1 busy low", pin_out, 0);
        core_busy = 0; #1;
        check("R1 ready high", pin_out, 1);
        cyc();
        irq_event = 1; cyc(); irq_event = 0;
        check("R10 event ignored in memory mode", pin_out, 1);
    endtask

    task automatic t_pulse();
        int lows = 0;
        mode_sel = 1; pulse_sel = 1; cyc();
        check("R3 io idle high", pin_out, 1);
        irq_event = 1; cyc(); irq_event = 0;
        for (int i = 0; i < 12; i++) begin
            if (pin_out == 0) lows++;
            irq_event = (i == 3);
            cyc();
        end
        irq_event = 0;
        check("R5 strobe length with retrigger", lows, 8);
        check("R3 io idle after strobe", pin_out, 1);
    endtask

    task automatic t_level();
        pulse_sel = 0; cyc();
        irq_event = 1; cyc(); irq_event = 0;
        check("R4 level set", pin_out, 0);
        cyc(5);
        check("R4 level held", pin_out, 0);
        irq_event = 1; irq_clear = 1; cyc(); irq_event = 0; irq_clear = 0;
        check("R4 event beats clear", pin_out, 0);
        irq_clear = 1; cyc(); irq_clear = 0;
        check("R4 cleared", pin_out, 1);
    endtask

    task automatic t_ide();
        mode_sel = 2; cyc();
        check("R6 ide idle low", pin_out, 0);
        irq_event = 1; cyc(); irq_event = 0;
        check("R6 ide set high", pin_out, 1);
        irq_mask = 1; #1;
        check("R7 mask forces low", pin_out, 0);
        cyc(2); irq_mask = 0; #1;
        check("R7 pending kept across mask", pin_out, 1);
        irq_clear = 1; cyc(); irq_clear = 0;
        check("R6 ide cleared", pin_out, 0);
    endtask

    task automatic t_mode_flush();
        irq_event = 1; cyc(); irq_event = 0;
        check("R8 ide pending before switch", pin_out, 1);
        mode_sel = 1; pulse_sel = 0; #1;
        check("R8 old mode until edge", pin_out, 1);
        cyc();
        check("R8 io idle after switch", pin_out, 1);
        irq_event = 1; cyc(); irq_event = 0;
        mode_sel = 2; cyc();
        check("R8 ide idle after switch from pending io", pin_out, 0);
        mode_sel = 3; cyc();
        check("R9 reserved oe", pin_oe, 0);
        check("R9 reserved pin", pin_out, 0);
        mode_sel = 0; cyc();
        check("R9 oe back in memory", pin_oe, 1);
        check("R1 memory ready after modes", pin_out, 1);
    endtask

    initial begin
        t_reset_ready();
        t_pulse();
        t_level();
        t_ide();
        t_mode_flush();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        total++; bad++;
        $display("FAIL watchdog: actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule